// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block links two 18-bit ports, A and B, through two independent storage paths: one carries A toward B and the other carries B toward A. Each path has its own set of controls. A pass control makes the path transparent. A strobe input, qualified by an active-low strobe gate, captures the source word on its rising transition. An active-low drive control decides whether the destination port is driven. When the pass control is low and no qualifying strobe edge arrives, the path holds its stored word.

The design runs from one system clock. The strobe inputs are sampled on that clock and edge-detected, so a strobe edge is recognised when the strobe reads 0 at one system clock and 1 at the next. It takes effect at that second system clock edge. In pass mode the destination output follows the source within the same cycle. Tri-state behaviour appears as a drive-enable bit beside each data output, not as an inout pin.

Top module: `ubr_top`

## Requirements
- R1: The two paths are independent. The A-to-B path (a_in to b_out and b_drive) responds only to the ab_* controls, and the B-to-A path (b_in to a_out and a_drive) responds only to the ba_* controls.
- R2: While a path's pass control (ab_le or ba_le) is 1, its destination data output equals its source input in the same cycle, and the stored word takes the source value at every system clock edge.
- R3: After the pass control falls, the destination shows the source value that was present at the last system clock edge where the pass control was 1. Later source changes have no effect until a capture.
- R4: With the pass control at 0 and the gate (ab_clken_n or ba_clken_n) at 0, a strobe that reads 0 at one system clock edge and 1 at the next captures the source at that second edge. The captured word appears on the destination output after that edge.
- R5: With the gate at 1, rising strobe transitions leave the stored word unchanged.
- R6: A strobe held steady at 0 or at 1, or falling from 1 to 0, leaves the stored word unchanged.
- R7: The drive output (b_drive or a_drive) is 1 exactly when that path's drive control (ab_oe_n or ba_oe_n) is 0 and reset is low. Turning the drive off does not alter the stored word, which still appears on the data output.
- R8: A synchronous reset clears both stored words to 0 and holds both drive outputs at 0. A strobe that is already high when reset is released is not taken as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Word received on port A |
| b_in | input | 18 | Word received on port B |
| ab_oe_n | input | 1 | A-to-B drive control, active low |
| ab_le | input | 1 | A-to-B pass control, active high |
| ab_clk | input | 1 | A-to-B capture strobe (sampled) |
| ab_clken_n | input | 1 | A-to-B strobe gate, active low |
| ba_oe_n | input | 1 | B-to-A drive control, active low |
| ba_le | input | 1 | B-to-A pass control, active high |
| ba_clk | input | 1 | B-to-A capture strobe (sampled) |
| ba_clken_n | input | 1 | B-to-A strobe gate, active low |
| b_out | output | 18 | Data presented toward port B |
| b_drive | output | 1 | Port B drive enable |
| a_out | output | 18 | Data presented toward port A |
| a_drive | output | 1 | Port A drive enable |

## Verification
A wrong stored word cannot be seen while the pass control is high. It appears on the destination data output in the first cycle after pass drops, and it stays there until the next qualified strobe edge. The bench therefore toggles the pass control, the strobe and the gate in near-exhaustive combinations and compares every cycle against a bench-side model of the stored word. A wrong strobe-history bit shows up one system clock later as a missed or spurious capture. A fault in the drive logic shows up at once on the drive bit.

// File: rtl/ubr_pkg.sv
`timescale 1ns/1ps
package ubr_pkg;

    localparam int unsigned BUS_W   = 18;
    localparam int unsigned N_PATHS = 2;

    // Controls for one direction of transfer
    typedef struct packed {
        logic drive_n;      // destination drive, active low
        logic pass;         // transparent when high
        logic strobe;       // sampled capture strobe
        logic gate_n;       // strobe qualifier, active low
    } dir_ctrl_t;

    typedef enum logic [1:0] {
        M_HOLD    = 2'd0,
        M_PASS    = 2'd1,
        M_CAPTURE = 2'd2
    } path_mode_e;

    // Pass wins over everything; a gated rising strobe captures.
    function automatic path_mode_e pick_mode(input logic pass,
                                             input logic rise,
                                             input logic gate_n);
        if (pass)
            return M_PASS;
        else if (rise && !gate_n)
            return M_CAPTURE;
        else
            return M_HOLD;
    endfunction

endpackage

// File: rtl/ubr_edge_det.sv
`timescale 1ns/1ps
module ubr_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev_q;

    // Loaded with the live level in reset too, so a strobe that is high
    // at release is never mistaken for an edge.
    always_ff @(posedge clk) begin
        prev_q <= lvl;
    end

    assign rise = lvl && !prev_q && !rst;

endmodule

// File: rtl/ubr_path.sv
`timescale 1ns/1ps
module ubr_path
    import ubr_pkg::*;
#(
    parameter int unsigned W = BUS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  dir_ctrl_t       ctrl,
    input  logic [W-1:0]    src,
    output logic [W-1:0]    dst,
    output logic            drive
);
    logic          rise;
    path_mode_e    mode;
    logic [W-1:0]  store_q;

    ubr_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ctrl.strobe),
        .rise (rise)
    );

    assign mode = pick_mode(ctrl.pass, rise, ctrl.gate_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else begin
            case (mode)
                M_PASS, M_CAPTURE: store_q <= src;
                default:           store_q <= store_q;
            endcase
        end
    end

    assign dst   = ctrl.pass ? src : store_q;
    assign drive = !ctrl.drive_n && !rst;

    // R2: while passing, the store tracks the source each edge
    p_follow_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl.pass |=> (store_q == $past(src)));

    // R4: a gated rising strobe captures the source
    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.pass && rise && !ctrl.gate_n) |=> (store_q == $past(src)));

    // R5: gate high blocks every strobe
    p_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.pass && ctrl.gate_n) |=> $stable(store_q));

    // R6: no rising strobe, no change
    p_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.pass && !rise) |=> $stable(store_q));

endmodule

// File: rtl/ubr_top.sv
`timescale 1ns/1ps
module ubr_top
    import ubr_pkg::*;
#(
    parameter int unsigned W = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  a_in,
    input  logic [W-1:0]  b_in,
    input  logic          ab_oe_n,
    input  logic          ab_le,
    input  logic          ab_clk,
    input  logic          ab_clken_n,
    input  logic          ba_oe_n,
    input  logic          ba_le,
    input  logic          ba_clk,
    input  logic          ba_clken_n,
    output logic [W-1:0]  b_out,
    output logic          b_drive,
    output logic [W-1:0]  a_out,
    output logic          a_drive
);
    localparam int unsigned P_AB = 0;
    localparam int unsigned P_BA = 1;

    dir_ctrl_t    ctl  [N_PATHS];
    logic [W-1:0] src  [N_PATHS];
    logic [W-1:0] dst  [N_PATHS];
    logic         drv  [N_PATHS];

    assign ctl[P_AB] = '{drive_n: ab_oe_n, pass: ab_le,
                         strobe: ab_clk, gate_n: ab_clken_n};
    assign ctl[P_BA] = '{drive_n: ba_oe_n, pass: ba_le,
                         strobe: ba_clk, gate_n: ba_clken_n};
    assign src[P_AB] = a_in;
    assign src[P_BA] = b_in;

    genvar d;
    generate
        for (d = 0; d < N_PATHS; d++) begin : g_dir
            ubr_path #(.W(W)) u_path (
                .clk   (clk),
                .rst   (rst),
                .ctrl  (ctl[d]),
                .src   (src[d]),
                .dst   (dst[d]),
                .drive (drv[d])
            );
        end
    endgenerate

    assign b_out   = dst[P_AB];
    assign b_drive = drv[P_AB];
    assign a_out   = dst[P_BA];
    assign a_drive = drv[P_BA];

    // R7: a disabled drive control never lets a port drive
    p_drive_off_r7: assert property (@(posedge clk) disable iff (rst)
        (ab_oe_n |-> !b_drive) and (ba_oe_n |-> !a_drive));

endmodule

// File: tb/tb_ubr_top.sv
`timescale 1ns/1ps
module tb_ubr_top;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         ab_oe_n, ab_le, ab_clk, ab_clken_n;
    logic         ba_oe_n, ba_le, ba_clk, ba_clken_n;
    logic [W-1:0] b_out, a_out;
    logic         b_drive, a_drive;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model of the two stored words and strobe history
    logic [W-1:0] mq_ab = '0, mq_ba = '0;
    logic         mp_ab = 1'b0, mp_ba = 1'b0;

    always #5 clk = ~clk;

    ubr_top #(.W(W)) dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_clken_n(ab_clken_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_clken_n(ba_clken_n),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string tag_for(input logic le, input logic rise, input logic gate_n);
        if (le) return "R2";
        if (!rise) return "R6";
        if (gate_n) return "R5";
        return "R4";
    endfunction

    // One system clock: model updates from the inputs held across the edge
    task automatic step();
        @(posedge clk);
        if (rst) begin
            mq_ab = '0;
            mq_ba = '0;
        end else begin
            if (ab_le) mq_ab = a_in;
            else if (ab_clk && !mp_ab && !ab_clken_n) mq_ab = a_in;
            if (ba_le) mq_ba = b_in;
            else if (ba_clk && !mp_ba && !ba_clken_n) mq_ba = b_in;
        end
        mp_ab = ab_clk;
        mp_ba = ba_clk;
        @(negedge clk);
    endtask

    function automatic logic [W-1:0] exp_ab();
        return ab_le ? a_in : mq_ab;
    endfunction
    function automatic logic [W-1:0] exp_ba();
        return ba_le ? b_in : mq_ba;
    endfunction

    task automatic check_all(input string t_ab, input string t_ba);
        chk(t_ab, b_out, exp_ab());
        chk(t_ba, a_out, exp_ba());
        chk("R7", W'(b_drive), W'(!ab_oe_n && !rst));
        chk("R7", W'(a_drive), W'(!ba_oe_n && !rst));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R8: reset clears, strobe high through release is no edge
        rst = 1; a_in = '1; b_in = 18'h2AAAA;
        ab_oe_n = 0; ab_le = 0; ab_clk = 1; ab_clken_n = 0;
        ba_oe_n = 0; ba_le = 0; ba_clk = 1; ba_clken_n = 0;
        @(negedge clk);
        step(); step();
        chk("R8", b_out, '0);
        chk("R8", a_out, '0);
        chk("R8", W'(b_drive), '0);
        chk("R8", W'(a_drive), '0);
        rst = 0;
        step();
        chk("R8", b_out, '0);
        chk("R8", a_out, '0);
        check_all("R8", "R8");

        // R4: gated rising strobe captures
        ab_clk = 0; step();
        a_in = 18'h01234; ab_clk = 1; step();
        chk("R4", b_out, 18'h01234);
        a_in = 18'h3F00F; step();
        chk("R6", b_out, 18'h01234);
        ab_clk = 0; a_in = 18'h15555; step();
        chk("R6", b_out, 18'h01234);

        // R5: gate high blocks the edge
        ab_clken_n = 1; step();
        ab_clk = 1; a_in = 18'h0BEEF; step();
        chk("R5", b_out, 18'h01234);
        ab_clken_n = 0;

        // R2 / R3: pass then hold the last passed value
        ab_le = 1; a_in = 18'h2C0DE; step();
        chk("R2", b_out, 18'h2C0DE);
        a_in = 18'h11111; #1;
        chk("R2", b_out, 18'h11111);
        step();
        ab_le = 0; a_in = 18'h07777; step();
        chk("R3", b_out, 18'h11111);

        // R7: drive off keeps data
        ab_oe_n = 1; step();
        chk("R7", W'(b_drive), '0);
        chk("R7", b_out, 18'h11111);
        ab_oe_n = 0; step();
        chk("R7", W'(b_drive), 18'd1);
        chk("R7", b_out, 18'h11111);

        // R1: churn B-to-A controls, A-to-B must not move
        for (int k = 0; k < 16; k++) begin
            ba_le = k[0]; ba_clk = k[1]; ba_clken_n = k[2]; ba_oe_n = k[3];
            b_in = W'(k * 4099 + 5);
            step();
            chk("R1", b_out, 18'h11111);
            chk("R1", a_out, exp_ba());
        end

        // Near-exhaustive sweep over both paths' control combinations
        for (int i = 0; i < 256; i++) begin
            int j;
            string t_ab, t_ba;
            j = (i * 7 + 3) % 256;
            ab_le = i[0] & i[5]; ab_clk = i[1]; ab_clken_n = i[2]; ab_oe_n = i[3] & i[4];
            ba_le = j[0] & j[6]; ba_clk = j[1]; ba_clken_n = j[2]; ba_oe_n = j[3] & j[4];
            a_in = W'(i * 10837 + 7);
            b_in = W'(j * 7919 + 11);
            t_ab = tag_for(ab_le, ab_clk && !mp_ab, ab_clken_n);
            t_ba = tag_for(ba_le, ba_clk && !mp_ba, ba_clken_n);
            step();
            check_all(t_ab, t_ba);
        end

        // R8: mid-run reset clears stored words
        rst = 1; step();
        check_all("R8", "R8");
        rst = 0; ab_le = 0; ba_le = 0; step();
        chk("R8", b_out, '0);
        chk("R8", a_out, '0);

        done = 1;
        summary();
        $finish;
    end
endmodule